// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit is a purely combinational execution stage for a 32-bit register datapath. It adds three register operations that a plain ALU lacks. The first is a half-split: one operand yields two zero-extended results, each meant for its own destination register. The second is a per-bit equality compare. The third is a mask-driven merge of a register with a sign-extended immediate.

The surrounding pipeline supplies two register operands, a 16-bit immediate and a 2-bit operation code. It takes back a primary result and a secondary result. It also takes a write flag that tells it whether the secondary result must be committed to a second register. The unit holds no state, so every output follows its inputs within the same cycle.

Decode is a single four-way selection over the operation code: SPLIT (00), BITEQ (01), MERGE (10) and NONE (11). There are no transitions, because there are no registers. Each code selects one datapath leaf, and the selection settles combinationally.

Top module: `bmx_unit`

## Requirements
- R1: With op_sel = 00 (split), res_pri equals the low 16 bits of opd_a, and bits 31:16 of res_pri are zero.
- R2: With op_sel = 00, res_sec equals bits 31:16 of opd_a, moved to bits 15:0 with bits 31:16 zero.
- R3: sec_wr_en is 1 exactly when op_sel = 00 and is 0 for every other code.
- R4: With op_sel = 01 (bit-equal), bit i of res_pri is 1 when bit i of opd_a equals bit i of opd_b, and 0 otherwise.
- R5: With op_sel = 10 (merge), opd_b is a mask: where a mask bit is 0, the res_pri bit is the opd_a bit.
- R6: With op_sel = 10, where a mask bit is 1, the res_pri bit is the matching bit of imm sign-extended to 32 bits, so bits 31:16 copy imm bit 15.
- R7: With op_sel = 11, res_pri and res_sec are both zero whatever the operands are.
- R8: For every op_sel other than 00, res_sec is zero.
- R9: The outputs are a function of the present inputs only: a given input set gives the same outputs whatever was applied before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | 32 | First register operand |
| opd_b | input | 32 | Second register operand; the mask for merge |
| imm | input | 16 | Immediate literal, sign-extended for merge |
| op_sel | input | 2 | Operation code: 00 split, 01 bit-equal, 10 merge, 11 none |
| res_pri | output | 32 | Primary result |
| res_sec | output | 32 | Secondary result, meaningful for split only |
| sec_wr_en | output | 1 | Secondary result should be written |

## Verification
The sign extension in the merge is the case most easily missed. With random operands, a mask whose upper half selects the immediate while imm bit 15 is set is rare, so directed cases force all-ones and upper-half-only masks with imm values on both sides of the sign bit. Split is exercised with operands whose two halves differ strongly, so that a swapped or sign-filled half is visible. Repeating one input set after unrelated operations shows that no history leaks into the outputs.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

    typedef enum logic [1:0] {
        OP_SPLIT = 2'b00,
        OP_BITEQ = 2'b01,
        OP_MERGE = 2'b10,
        OP_NONE  = 2'b11
    } bmx_op_e;

endpackage

// File: rtl/bmx_split.sv
module bmx_split #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] lo_ext,
    output logic [DATA_W-1:0] hi_ext
);
    localparam int LO_W = DATA_W / 2;
    localparam int HI_W = DATA_W - LO_W;

    // low half, zero-extended
    assign lo_ext = {{HI_W{1'b0}}, src[LO_W-1:0]};
    // high half brought down, zero-filled
    assign hi_ext = {{LO_W{1'b0}}, src[DATA_W-1:LO_W]};
endmodule

// File: rtl/bmx_biteq.sv
module bmx_biteq #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] same
);
    assign same = ~(lhs ^ rhs);
endmodule

// File: rtl/bmx_merge.sv
module bmx_merge #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] mask,
    input  logic [IMM_W-1:0]  lit,
    output logic [DATA_W-1:0] merged
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] lit_sx;
    assign lit_sx = {{EXT_W{lit[IMM_W-1]}}, lit};

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign merged[i] = mask[i] ? lit_sx[i] : base[i];
    end
endmodule

// File: rtl/bmx_unit.sv
module bmx_unit
    import bmx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] opd_a,
    input  logic [DATA_W-1:0] opd_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [1:0]        op_sel,
    output logic [DATA_W-1:0] res_pri,
    output logic [DATA_W-1:0] res_sec,
    output logic              sec_wr_en
);
    bmx_op_e           op;
    logic [DATA_W-1:0] split_lo;
    logic [DATA_W-1:0] split_hi;
    logic [DATA_W-1:0] eq_bits;
    logic [DATA_W-1:0] mrg_bits;

    assign op = bmx_op_e'(op_sel);

    bmx_split #(.DATA_W(DATA_W)) u_split (
        .src    (opd_a),
        .lo_ext (split_lo),
        .hi_ext (split_hi)
    );

    bmx_biteq #(.DATA_W(DATA_W)) u_biteq (
        .lhs  (opd_a),
        .rhs  (opd_b),
        .same (eq_bits)
    );

    bmx_merge #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_merge (
        .base   (opd_a),
        .mask   (opd_b),
        .lit    (imm),
        .merged (mrg_bits)
    );

    always_comb begin
        res_pri   = '0;
        res_sec   = '0;
        sec_wr_en = 1'b0;
        unique case (op)
            OP_SPLIT: begin
                res_pri   = split_lo;
                res_sec   = split_hi;
                sec_wr_en = 1'b1;
            end
            OP_BITEQ: res_pri = eq_bits;
            OP_MERGE: res_pri = mrg_bits;
            OP_NONE:  res_pri = '0;
        endcase
    end
endmodule

// File: rtl/bmx_unit_chk.sv
module bmx_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input logic [DATA_W-1:0] opd_a,
    input logic [DATA_W-1:0] opd_b,
    input logic [IMM_W-1:0]  imm,
    input logic [1:0]        op_sel,
    input logic [DATA_W-1:0] res_pri,
    input logic [DATA_W-1:0] res_sec,
    input logic              sec_wr_en
);
    localparam int LO_W = DATA_W / 2;

    logic [DATA_W-1:0] imm_wide;
    assign imm_wide = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};

    always_comb begin
        if (!$isunknown({opd_a, opd_b, imm, op_sel, res_pri, res_sec, sec_wr_en})) begin
            a_r3_sec_flag: assert (sec_wr_en == (op_sel == 2'b00));
            if (op_sel == 2'b00) begin
                a_r1_split_upper_zero: assert (res_pri[DATA_W-1:LO_W] == '0);
                a_r2_split_recombine: assert ({res_sec[DATA_W-LO_W-1:0], res_pri[LO_W-1:0]} == opd_a);
            end
            if (op_sel == 2'b01) begin
                a_r4_biteq: assert ((res_pri ^ opd_a ^ opd_b) == '1);
            end
            if (op_sel == 2'b10) begin
                a_r5_mask_keep: assert (((res_pri ^ opd_a) & ~opd_b) == '0);
                a_r6_mask_take: assert (((res_pri ^ imm_wide) & opd_b) == '0);
            end
            if (op_sel == 2'b11) begin
                a_r7_none_zero: assert (res_pri == '0 && res_sec == '0);
            end
            if (op_sel != 2'b00) begin
                a_r8_sec_zero: assert (res_sec == '0);
            end
        end
    end
endmodule

bind bmx_unit bmx_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .opd_a     (opd_a),
    .opd_b     (opd_b),
    .imm       (imm),
    .op_sel    (op_sel),
    .res_pri   (res_pri),
    .res_sec   (res_sec),
    .sec_wr_en (sec_wr_en)
);

// File: tb/bmx_unit_bench.sv
`timescale 1ns/1ps
module bmx_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opd_a = '0;
    logic [31:0] opd_b = '0;
    logic [15:0] imm = '0;
    logic [1:0]  op_sel = 2'b11;
    logic [31:0] res_pri;
    logic [31:0] res_sec;
    logic        sec_wr_en;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    bmx_unit u_bmx_unit (
        .opd_a(opd_a), .opd_b(opd_b), .imm(imm), .op_sel(op_sel),
        .res_pri(res_pri), .res_sec(res_sec), .sec_wr_en(sec_wr_en)
    );

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] i);
        @(negedge clk);
        op_sel = o; opd_a = a; opd_b = b; imm = i;
        #1;
    endtask

    task automatic t_idle();
        chk("R7 idle pri", res_pri, 32'h0);
        chk("R7 idle sec", res_sec, 32'h0);
        chk("R3 idle flag", {31'h0, sec_wr_en}, 32'h0);
    endtask

    task automatic t_split(input logic [31:0] a);
        apply(2'b00, a, 32'hDEAD_BEEF, 16'h8001);
        chk("R1 split pri", res_pri, {16'h0, a[15:0]});
        chk("R2 split sec", res_sec, {16'h0, a[31:16]});
        chk("R3 split flag", {31'h0, sec_wr_en}, 32'h1);
    endtask

    task automatic t_biteq(input logic [31:0] a, input logic [31:0] b);
        apply(2'b01, a, b, 16'hFFFF);
        chk("R4 biteq pri", res_pri, ~(a ^ b));
        chk("R8 biteq sec", res_sec, 32'h0);
        chk("R3 biteq flag", {31'h0, sec_wr_en}, 32'h0);
    endtask

    task automatic t_merge(input logic [31:0] a, input logic [31:0] m, input logic [15:0] i);
        apply(2'b10, a, m, i);
        chk("R5 R6 merge pri", res_pri, (a & ~m) | (sx(i) & m));
        chk("R8 merge sec", res_sec, 32'h0);
        chk("R3 merge flag", {31'h0, sec_wr_en}, 32'h0);
    endtask

    task automatic t_none(input logic [31:0] a, input logic [31:0] b);
        apply(2'b11, a, b, 16'hA5A5);
        chk("R7 none pri", res_pri, 32'h0);
        chk("R7 none sec", res_sec, 32'h0);
        chk("R3 none flag", {31'h0, sec_wr_en}, 32'h0);
    endtask

    task automatic t_history();
        logic [31:0] first;
        apply(2'b10, 32'h1234_5678, 32'h0F0F_F0F0, 16'h9ABC);
        first = res_pri;
        apply(2'b00, 32'hFFFF_0000, 32'h0, 16'h0);
        apply(2'b01, 32'h0, 32'hFFFF_FFFF, 16'h0);
        apply(2'b10, 32'h1234_5678, 32'h0F0F_F0F0, 16'h9ABC);
        chk("R9 repeat same", res_pri, first);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        t_idle();
        t_split(32'hABCD_1234);
        t_split(32'h8000_7FFF);
        t_split(32'hFFFF_FFFF);
        t_biteq(32'h5555_5555, 32'h5555_5555);
        t_biteq(32'h5555_5555, 32'hAAAA_AAAA);
        t_biteq(32'hF0F0_1234, 32'h0FF0_1235);
        t_merge(32'h1234_5678, 32'h0000_0000, 16'hFFFF);
        t_merge(32'h1234_5678, 32'hFFFF_FFFF, 16'h8001);
        t_merge(32'h1234_5678, 32'hFFFF_FFFF, 16'h7FFE);
        t_merge(32'h0000_0000, 32'hFFFF_0000, 16'h8000);
        t_merge(32'hFFFF_FFFF, 32'hFFFF_0000, 16'h0001);
        t_merge(32'hAAAA_AAAA, 32'h5555_5555, 16'hC3C3);
        t_none(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        t_history();
        for (int k = 0; k < 200; k++) begin
            logic [31:0] ra, rb;
            logic [15:0] ri;
            ra = $urandom; rb = $urandom; ri = 16'($urandom);
            unique case (k % 4)
                0: t_split(ra);
                1: t_biteq(ra, rb);
                2: t_merge(ra, rb, ri);
                default: t_none(ra, rb);
            endcase
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule